// File: doc/BRIEF.md
# Debug Register Access Controller

This block holds the debug register file of a processor core: one address register per breakpoint slot, a status register and a control register. The core reaches them through a small request port. Each request carries a register index, a read/write flag and write data. One cycle later the block returns a response. The response carries read data, or an illegal-opcode fault with a zero error code when the index is not allowed.

Every stored value is presented in parallel to the breakpoint match unit. A write to the control register also reports which breakpoint slots the match unit has to set up again. It refreshes a flag that tells the core whether any enabled slot watches port I/O.

The two reserved indices depend on a debug-extensions enable input. When the input is set, both reserved indices fault. When it is clear, they act as second names for the status and control registers. Privilege checks and address matching belong to other blocks.

Top module: `dbgreg_access`

## Requirements
- R1: While reset is high and after it falls, with no request made, the address registers read 0, the status register reads 0xFFFF0FF0, the control register reads 0x00000400, io_bp_active is 0, and rsp_valid, rsp_fault and slot_reconfig are 0.
- R2: Indices 0 to 3 select address registers 0 to 3. A write stores the data unchanged and shows it on addr_bus bits [32*i+31:32*i]. A read returns the stored value. A write to address slot i also pulses slot_reconfig bit i for one cycle.
- R3: A write to index 6 stores the written value ORed with 0xFFFF0FF0 into the status register. A read of index 6 returns the stored value.
- R4: A write to index 7 stores the written value ORed with 0x00000400 into the control register. A read of index 7 returns the stored value.
- R5: With dbg_ext_en high, any access to index 4 or 5 faults. Such an access changes no register and returns read data 0.
- R6: With dbg_ext_en low, index 4 reads and writes the status register and index 5 reads and writes the control register, with the same fixed-one masks as R3 and R4.
- R7: An access to indices 8 to 15 faults and changes no register. rsp_err is 0 on every response.
- R8: A request in one cycle gives rsp_valid in the next cycle and no other cycle. Reads return the register value held before the edge. Writes and faults return read data 0.
- R9: A control write whose masked new value differs from the old value only in bits [7:0] pulses slot_reconfig bit i exactly when the slot's combined enable (bit 2i OR bit 2i+1) changes.
- R10: A control write whose masked new value differs from the old value in any bit above bit 7 pulses all four slot_reconfig bits.
- R11: After each control write, io_bp_active is 1 exactly when some slot i is enabled (bit 2i or 2i+1 set) and has type field bits [17+4i:16+4i] equal to 2'b10. The flag changes only on control writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 4 | Register index |
| req_wdata | input | 32 | Write data |
| dbg_ext_en | input | 1 | Debug-extensions enable; makes indices 4 and 5 fault |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_fault | output | 1 | Illegal-opcode fault |
| rsp_err | output | 16 | Fault error code, always 0 |
| rsp_rdata | output | 32 | Read data |
| addr_bus | output | 128 | All address registers, slot i at bits [32*i+31:32*i] |
| status_reg | output | 32 | Status register |
| ctrl_reg | output | 32 | Control register |
| slot_reconfig | output | 4 | One-cycle pulse per slot that needs setting up again |
| io_bp_active | output | 1 | Some enabled slot watches port I/O |

## Verification
The hardest case is a control write that picks the low-byte path (R9). Its masked value has to match the old one in every bit above bit 7. Random data almost never does that, and bit 10 is forced to one whatever was written. The stimulus therefore builds many control writes from the bench model's current control value plus a random low byte. Some of them clear bit 10 on purpose, so the mask must stop them from counting as a high-bit change. Directed writes also toggle only the local or only the global enable of a slot that is already on, which must leave that slot's reconfig bit clear.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;

  // Where a request lands after index decoding
  typedef enum logic [1:0] {
    TGT_ADDR = 2'd0,
    TGT_STAT = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_BAD  = 2'd3
  } dbg_tgt_e;

  localparam int IDX_ALIAS_STAT = 4;
  localparam int IDX_ALIAS_CTRL = 5;
  localparam int IDX_STAT       = 6;
  localparam int IDX_CTRL       = 7;

  // Control register layout used by the slot logic
  localparam int        TYPE_LSB     = 16;
  localparam int        SLOT_FIELD_W = 4;
  localparam logic [1:0] TYPE_PORT_IO = 2'b10;

endpackage

// File: rtl/dbgreg_decode.sv
module dbgreg_decode
  import dbgreg_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 4,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              ext_en,
  output dbg_tgt_e          tgt,
  output logic [SLOT_W-1:0] slot
);

  logic [31:0] idx_wide;

  always_comb begin
    idx_wide = 32'(idx);
    tgt      = TGT_BAD;
    slot     = '0;
    if (idx_wide < 32'(NUM_SLOTS)) begin
      tgt  = TGT_ADDR;
      slot = idx[SLOT_W-1:0];
    end else if (idx_wide == 32'(IDX_STAT)) begin
      tgt = TGT_STAT;
    end else if (idx_wide == 32'(IDX_CTRL)) begin
      tgt = TGT_CTRL;
    end else if (idx_wide == 32'(IDX_ALIAS_STAT)) begin
      tgt = ext_en ? TGT_BAD : TGT_STAT;
    end else if (idx_wide == 32'(IDX_ALIAS_CTRL)) begin
      tgt = ext_en ? TGT_BAD : TGT_CTRL;
    end
  end

endmodule

// File: rtl/dbgreg_ctrl_update.sv
module dbgreg_ctrl_update
  import dbgreg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 4
) (
  input  logic [DATA_W-1:0]    old_ctrl,
  input  logic [DATA_W-1:0]    new_ctrl,
  output logic [NUM_SLOTS-1:0] reconfig,
  output logic                 io_active
);

  localparam int EN_W = 2 * NUM_SLOTS;

  logic                 high_diff;
  logic [NUM_SLOTS-1:0] io_hit;

  assign high_diff = (old_ctrl[DATA_W-1:EN_W] != new_ctrl[DATA_W-1:EN_W]);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic       old_on;
    logic       new_on;
    logic [1:0] kind;
    assign old_on    = old_ctrl[2*s] | old_ctrl[2*s+1];
    assign new_on    = new_ctrl[2*s] | new_ctrl[2*s+1];
    assign kind      = new_ctrl[TYPE_LSB + SLOT_FIELD_W*s +: 2];
    assign io_hit[s] = new_on && (kind == TYPE_PORT_IO);
    assign reconfig[s] = high_diff | (old_on ^ new_on);
  end

  assign io_active = |io_hit;

endmodule

// File: rtl/dbgreg_addr_bank.sv
module dbgreg_addr_bank #(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [SLOT_W-1:0]           slot,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic [NUM_SLOTS*DATA_W-1:0] bus
);

  logic [DATA_W-1:0] slot_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[s] <= '0;
      end else if (we && (32'(slot) == s)) begin
        slot_q[s] <= wdata;
      end
    end
    assign bus[s*DATA_W +: DATA_W] = slot_q[s];
  end

  assign rdata = slot_q[slot];

  // R2: a write lands in the selected slot unchanged
  a_r2_slot_write: assert property (@(posedge clk) disable iff (rst)
    we |=> (slot_q[$past(slot)] == $past(wdata)));

endmodule

// File: rtl/dbgreg_access.sv
module dbgreg_access
  import dbgreg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 4,
  parameter int ERR_W     = 16,
  parameter logic [DATA_W-1:0] STATUS_ONES = 32'hFFFF_0FF0,
  parameter logic [DATA_W-1:0] CTRL_ONES   = 32'h0000_0400,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [IDX_W-1:0]            req_idx,
  input  logic [DATA_W-1:0]           req_wdata,
  input  logic                        dbg_ext_en,
  output logic                        rsp_valid,
  output logic                        rsp_fault,
  output logic [ERR_W-1:0]            rsp_err,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic [NUM_SLOTS*DATA_W-1:0] addr_bus,
  output logic [DATA_W-1:0]           status_reg,
  output logic [DATA_W-1:0]           ctrl_reg,
  output logic [NUM_SLOTS-1:0]        slot_reconfig,
  output logic                        io_bp_active
);

  dbg_tgt_e             tgt;
  logic [SLOT_W-1:0]    slot;
  logic                 wr;
  logic                 addr_we;
  logic                 stat_we;
  logic                 ctrl_we;
  logic [DATA_W-1:0]    addr_rd;
  logic [DATA_W-1:0]    ctrl_next;
  logic [NUM_SLOTS-1:0] upd_reconfig;
  logic                 upd_io;
  logic [DATA_W-1:0]    status_q;
  logic [DATA_W-1:0]    ctrl_q;

  dbgreg_decode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_decode (
    .idx    (req_idx),
    .ext_en (dbg_ext_en),
    .tgt    (tgt),
    .slot   (slot)
  );

  assign wr      = req_valid && req_write;
  assign addr_we = wr && (tgt == TGT_ADDR);
  assign stat_we = wr && (tgt == TGT_STAT);
  assign ctrl_we = wr && (tgt == TGT_CTRL);
  assign ctrl_next = req_wdata | CTRL_ONES;

  dbgreg_addr_bank #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) u_addr (
    .clk   (clk),
    .rst   (rst),
    .we    (addr_we),
    .slot  (slot),
    .wdata (req_wdata),
    .rdata (addr_rd),
    .bus   (addr_bus)
  );

  dbgreg_ctrl_update #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) u_upd (
    .old_ctrl  (ctrl_q),
    .new_ctrl  (ctrl_next),
    .reconfig  (upd_reconfig),
    .io_active (upd_io)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q      <= STATUS_ONES;
      ctrl_q        <= CTRL_ONES;
      io_bp_active  <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_rdata     <= '0;
      slot_reconfig <= '0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_fault     <= req_valid && (tgt == TGT_BAD);
      rsp_rdata     <= '0;
      slot_reconfig <= '0;
      if (req_valid && !req_write) begin
        case (tgt)
          TGT_ADDR: rsp_rdata <= addr_rd;
          TGT_STAT: rsp_rdata <= status_q;
          TGT_CTRL: rsp_rdata <= ctrl_q;
          default:  rsp_rdata <= '0;
        endcase
      end
      if (addr_we) begin
        slot_reconfig <= {{(NUM_SLOTS-1){1'b0}}, 1'b1} << slot;
      end
      if (stat_we) begin
        status_q <= req_wdata | STATUS_ONES;
      end
      if (ctrl_we) begin
        ctrl_q        <= ctrl_next;
        slot_reconfig <= upd_reconfig;
        io_bp_active  <= upd_io;
      end
    end
  end

  assign rsp_err    = '0;
  assign status_reg = status_q;
  assign ctrl_reg   = ctrl_q;

  // R8: exactly one response per request, one cycle later
  a_r8_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r8_no_rsp_without_req: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R5: reserved indices fault while extensions are on
  a_r5_reserved_fault: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dbg_ext_en && (32'(req_idx) == IDX_ALIAS_STAT || 32'(req_idx) == IDX_ALIAS_CTRL))
    |=> rsp_fault);
  // R7: a faulting access leaves status and control untouched
  a_r7_fault_no_change: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (ctrl_q == $past(ctrl_q)) && (status_q == $past(status_q)));
  // R4: control fixed-one bits always present
  a_r4_ctrl_fixed: assert property (@(posedge clk) disable iff (rst)
    (ctrl_reg & CTRL_ONES) == CTRL_ONES);
  // R9: reconfig pulses only after a write
  a_r9_reconfig_after_write: assert property (@(posedge clk) disable iff (rst)
    (|slot_reconfig) |-> $past(wr));
  // R11: the I/O flag moves only on control writes
  a_r11_io_on_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    !$stable(io_bp_active) |-> $past(ctrl_we));

endmodule

// File: tb/tb_dbgreg_access.sv
module tb_dbgreg_access;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [3:0]   req_idx = 4'd0;
  logic [31:0]  req_wdata = 32'd0;
  logic         dbg_ext_en = 1'b0;
  logic         rsp_valid;
  logic         rsp_fault;
  logic [15:0]  rsp_err;
  logic [31:0]  rsp_rdata;
  logic [127:0] addr_bus;
  logic [31:0]  status_reg;
  logic [31:0]  ctrl_reg;
  logic [3:0]   slot_reconfig;
  logic         io_bp_active;

  always #4 clk = ~clk;

  dbgreg_access dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .req_wdata(req_wdata), .dbg_ext_en(dbg_ext_en),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .addr_bus(addr_bus), .status_reg(status_reg),
    .ctrl_reg(ctrl_reg), .slot_reconfig(slot_reconfig), .io_bp_active(io_bp_active)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model state
  logic [31:0] m_addr [4];
  logic [31:0] m_stat;
  logic [31:0] m_ctrl;
  logic        m_io;
  logic        e_valid;
  logic        e_fault;
  logic [31:0] e_rdata;
  logic [3:0]  e_reconf;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit on_of(input logic [31:0] c, input int s);
    return ((c >> (2*s)) & 32'd3) != 32'd0;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 4; s++) m_addr[s] = 32'd0;
    m_stat = 32'hFFFF0FF0;
    m_ctrl = 32'h00000400;
    m_io = 1'b0;
    e_valid = 1'b0; e_fault = 1'b0; e_rdata = 32'd0; e_reconf = 4'd0;
  endtask

  task automatic model_step(input bit v, input bit w, input int idx, input logic [31:0] d, input bit ext);
    int kind;
    logic [31:0] nv;
    e_valid = v; e_fault = 1'b0; e_rdata = 32'd0; e_reconf = 4'd0;
    if (!v) return;
    if (idx < 4) kind = 0;
    else if (idx == 6 || (idx == 4 && !ext)) kind = 1;
    else if (idx == 7 || (idx == 5 && !ext)) kind = 2;
    else kind = 3;
    if (kind == 3) begin
      e_fault = 1'b1;
      return;
    end
    if (!w) begin
      if (kind == 0) e_rdata = m_addr[idx];
      else if (kind == 1) e_rdata = m_stat;
      else e_rdata = m_ctrl;
      return;
    end
    if (kind == 0) begin
      m_addr[idx] = d;
      e_reconf = 4'(1 << idx);
    end else if (kind == 1) begin
      m_stat = d | 32'hFFFF0FF0;
    end else begin
      nv = d | 32'h00000400;
      m_io = 1'b0;
      for (int s = 0; s < 4; s++) begin
        if (((m_ctrl ^ nv) & 32'hFFFFFF00) != 32'd0) e_reconf[s] = 1'b1;
        else e_reconf[s] = on_of(m_ctrl, s) != on_of(nv, s);
        if (on_of(nv, s) && (((nv >> (16 + 4*s)) & 32'd3) == 32'd2)) m_io = 1'b1;
      end
      m_ctrl = nv;
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " R8 rsp_valid"}, 32'(rsp_valid), 32'(e_valid));
    chk({tag, " R5 R7 rsp_fault"}, 32'(rsp_fault), 32'(e_fault));
    chk({tag, " R7 rsp_err"}, 32'(rsp_err), 32'd0);
    chk({tag, " R2 R6 R8 rsp_rdata"}, rsp_rdata, e_rdata);
    for (int s = 0; s < 4; s++) chk({tag, " R2 addr_bus"}, addr_bus[32*s +: 32], m_addr[s]);
    chk({tag, " R3 R6 status_reg"}, status_reg, m_stat);
    chk({tag, " R4 R6 ctrl_reg"}, ctrl_reg, m_ctrl);
    chk({tag, " R9 R10 slot_reconfig"}, 32'(slot_reconfig), 32'(e_reconf));
    chk({tag, " R11 io_bp_active"}, 32'(io_bp_active), 32'(m_io));
  endtask

  task automatic req(input bit v, input bit w, input int idx, input logic [31:0] d, input bit ext, input string tag);
    req_valid = v; req_write = w; req_idx = 4'(idx); req_wdata = d; dbg_ext_en = ext;
    model_step(v, w, idx, d, ext);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] d;
    model_reset();
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst = 1'b0;
    @(negedge clk);
    compare_all("R1 idle after reset");

    // R2 address registers
    for (int s = 0; s < 4; s++) req(1, 1, s, 32'h1000_0000 + 32'(s * 16'h1111), 0, "R2 write");
    for (int s = 0; s < 4; s++) req(1, 0, s, 32'd0, 0, "R2 read");
    // R3 status
    req(1, 1, 6, 32'h0000_0000, 0, "R3 write zero");
    req(1, 0, 6, 32'd0, 0, "R3 read");
    req(1, 1, 6, 32'h0000_F00F, 0, "R3 write bits");
    // R4 and R9 low-only paths
    req(1, 1, 7, 32'h0000_0001, 0, "R9 enable slot0 local");
    req(1, 1, 7, 32'h0000_0003, 0, "R9 add global no change");
    req(1, 1, 7, 32'h0000_0002, 0, "R9 drop local no change");
    req(1, 1, 7, 32'h0000_00C2, 0, "R9 enable slot3 global");
    req(1, 0, 7, 32'd0, 0, "R4 read");
    // R10 high change, R11 io type on slot0
    req(1, 1, 7, 32'h0002_00C2, 0, "R10 R11 io slot0");
    req(1, 1, 7, 32'h0002_00C0, 0, "R9 R11 disable io slot");
    req(1, 1, 7, 32'h2002_00C0, 0, "R10 R11 io slot3");
    req(1, 1, 7, 32'h2002_0000, 0, "R11 io slot disabled");
    // R5 reserved with extensions on
    req(1, 1, 4, 32'h1234_5678, 1, "R5 write idx4");
    req(1, 1, 5, 32'h1234_5678, 1, "R5 write idx5");
    req(1, 0, 4, 32'd0, 1, "R5 read idx4");
    req(1, 0, 5, 32'd0, 1, "R5 read idx5");
    // R6 aliases with extensions off
    req(1, 1, 4, 32'h0000_A005, 0, "R6 write alias status");
    req(1, 0, 4, 32'd0, 0, "R6 read alias status");
    req(1, 1, 5, 32'h0000_0010, 0, "R6 write alias ctrl");
    req(1, 0, 5, 32'd0, 0, "R6 read alias ctrl");
    // R7 out-of-range
    req(1, 1, 8, 32'hFFFF_FFFF, 0, "R7 write idx8");
    req(1, 0, 15, 32'd0, 1, "R7 read idx15");
    req(0, 1, 7, 32'hFFFF_FFFF, 0, "R8 no request");

    // Random traffic, biased towards low-byte control writes
    for (int n = 0; n < 4000; n++) begin
      int idx;
      bit v, w, ext;
      v = ($urandom % 4) != 0;
      w = ($urandom % 2) != 0;
      ext = ($urandom % 2) != 0;
      idx = int'($urandom % 16);
      d = $urandom;
      if (($urandom % 3) == 0) begin
        idx = 7;
        d = (m_ctrl & 32'hFFFF_FF00) | (d & 32'h0000_00FF);
        if (($urandom % 2) != 0) d = d & ~32'h0000_0400;
      end
      req(v, w, idx, d, ext, "random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule